// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

A synthesizable slave model of a 256-byte serial memory on a two-wire bus. SCL and SDA are sampled on a fast system clock, passed through a synchronizer, and decoded into start, stop and clock-edge events. The block takes a device-select byte and an 8-bit word address. It then either buffers write data for one 8-byte page or streams read data out from an auto-incrementing pointer.

SDA is driven only as an open-drain pull-down enable. A write-protect input freezes the upper half of the array. After each committed write, a parameterized busy counter models the internal programming time. While it runs, the block does not answer the bus.

Top module: `eep_i2c_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) in any state begins reception of a new select byte. A stop (SDA rising while SCL is high) returns the block to idle. This includes a stop in the middle of a byte.
- R2: `sda_oe_o` only pulls SDA low or releases it. It changes only after a falling SCL edge, or as a release on a start or stop.
- R3: The select byte is sent MSB first with the fields {4'b1010, dev_addr_i[2:0], rw}, where rw=1 means read. A matching select is acknowledged by pulling SDA low on the ninth clock. Any other select is not acknowledged, and the block ignores the bus until the next start.
- R4: After a write select, the next byte is acknowledged and loaded as the word pointer. Each following data byte is acknowledged.
- R5: Data bytes of one write go to pointer bits 7:3 with bits 2:0 incrementing and wrapping within the 8-byte page. A later byte that lands on the same offset replaces the earlier one.
- R6: Buffered data is written to the array only on a stop. A repeated start discards it.
- R7: With `wp_i`=1, writes to 0x80..0xFF leave the array unchanged, while 0x00..0x7F stay writable. With `wp_i`=0, every address is writable.
- R8: After a write commit, no select is acknowledged for BUSY_CYCLES clock cycles. After that, selects are acknowledged again.
- R9: Read data is sent MSB first and changes after falling SCL edges. In a sequential read, the pointer increments after each byte the master acknowledges, wrapping from 0xFF to 0x00. A random read sets the pointer with a write select and address, then a repeated start and a read select.
- R10: A read byte that the master does not acknowledge ends the read, and SDA stays released.
- R11: After reset the block is idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| dev_addr_i | input | 3 | Hard-wired device address, compared with select bits 3:1 |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A table of single-byte writes, each followed by a random read, covers addresses at both ends of each half of the array and data with alternating and extreme bit patterns. This separates pointer loading and bit ordering from storage faults. A ten-byte write that starts at offset 6 separates in-page wrap from linear increment, because the overwritten offsets differ between the two. A sequential read across 0xFF shows whether the pointer wraps or stops. Foreign selects, repeated starts without a stop, an aborted byte, and selects placed inside and after the busy window each distinguish a block that answers only when it should from one that answers too freely.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // R1: SDA edges while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [PAGE_W-1:0]            off_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [PAGE_BYTES*DATA_W-1:0] data_o,
  output logic [PAGE_BYTES-1:0]        mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mask_o <= '0;
    end else if (clr_i) begin
      mask_o <= '0;
    end else if (wr_i) begin
      for (int l = 0; l < PAGE_BYTES; l++) begin
        if (off_i == PAGE_W'(l)) begin
          data_o[l*DATA_W +: DATA_W] <= data_i;
          mask_o[l]                  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH      = 1 << ADDR_W,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PAGE_AW    = ADDR_W - PAGE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         wp_i,
  input  logic [PAGE_AW-1:0]           page_i,
  input  logic [PAGE_BYTES-1:0]        mask_i,
  input  logic [PAGE_BYTES*DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0]            raddr_i,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              locked;

  // R7: upper half frozen while protected
  assign locked = wp_i & page_i[PAGE_AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && !locked) begin
      for (int l = 0; l < PAGE_BYTES; l++)
        if (mask_i[l]) mem[{page_i, PAGE_W'(l)}] <= data_i[l*DATA_W +: DATA_W];
    end
  end

  assign rdata_o = mem[raddr_i];

  for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_chk
    a_r7_upper_page_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wp_i |=> $stable(mem[DEPTH-PAGE_BYTES+l]));
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PAGE_AW    = ADDR_W - PAGE_W,
  localparam int BUSY_W     = $clog2(BUSY_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_addr_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  eep_state_e          state;
  logic [3:0]          bit_cnt;
  logic [7:0]          shreg;
  logic [ADDR_W-1:0]   ptr;
  logic                oe, master_ack;
  logic [BUSY_W-1:0]   busy_cnt;
  logic                busy, sel_match, commit, buf_wr;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [7:0]          rdata;

  assign busy      = busy_cnt != '0;
  assign sel_match = shreg[7:4] == DEV_CODE && shreg[3:1] == dev_addr_i && !busy;
  assign commit    = stop && state == ST_WDATA && |buf_mask;   // R6
  assign buf_wr    = scl_fall && bit_cnt == 4'd8 && state == ST_WDATA;

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) i_buf (
    .clk_i, .rst_ni, .clr_i(start | commit), .wr_i(buf_wr),
    .off_i(ptr[PAGE_W-1:0]), .data_i(shreg), .data_o(buf_data), .mask_o(buf_mask)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(8)) i_array (
    .clk_i, .rst_ni, .we_i(commit), .wp_i, .page_i(ptr[ADDR_W-1:PAGE_W]),
    .mask_i(buf_mask), .data_i(buf_data), .raddr_i(ptr), .rdata_o(rdata)
  );

  // R8: internal write time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (commit) busy_cnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy)   busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      ptr        <= '0;
      oe         <= 1'b0;
      master_ack <= 1'b0;
    end else if (start) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      oe      <= 1'b0;
    end else if (stop) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      oe      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= 4'd9;
            if (state != ST_DEV || sel_match) oe <= 1'b1;   // R3, R4
            else state <= ST_IDLE;
            if (state == ST_ADDR) ptr <= shreg;
            if (state == ST_WDATA) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1); // R5
          end else if (scl_fall && bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            oe      <= 1'b0;
            if (state == ST_DEV && shreg[0]) begin
              state <= ST_RDATA;
              shreg <= rdata;
              oe    <= ~rdata[7];
            end else if (state == ST_DEV) begin
              state <= ST_ADDR;
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_rise && bit_cnt == 4'd8) begin
            bit_cnt    <= 4'd9;
            master_ack <= ~sda_s;
            if (!sda_s) ptr <= ptr + 1'b1;   // R9
          end else if (scl_fall && bit_cnt != 4'd0 && bit_cnt < 4'd8) begin
            shreg <= {shreg[6:0], 1'b0};
            oe    <= ~shreg[6];
          end else if (scl_fall && bit_cnt == 4'd8) begin
            oe <= 1'b0;
          end else if (scl_fall && bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            if (master_ack) begin
              shreg <= rdata;
              oe    <= ~rdata[7];
            end else begin
              state <= ST_IDLE;   // R10
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe;

  a_r2_oe_moves_with_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe) |-> !$past(scl_s) || $past(start || stop));
  a_r8_no_ack_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && state == ST_DEV) |-> !oe);
  a_r5_ptr_stays_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WDATA && $past(state) == ST_WDATA)
      |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  a_r11_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !oe);
endmodule

// File: tb/test_eep_i2c_slave.sv
`timescale 1ns/1ps
module test_eep_i2c_slave;
  localparam int BUSY = 400;
  localparam int Q    = 6;
  localparam logic [7:0] SEL_W = 8'hAA;   // 1010_101_0
  localparam logic [7:0] SEL_R = 8'hAB;
  // {address, data}
  localparam logic [15:0] VEC [8] = '{16'h00_3C, 16'h01_C3, 16'h3F_5A, 16'h7F_81,
                                      16'h80_7E, 16'hA5_96, 16'hFE_E1, 16'hFF_1F};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_bus;
  int checks = 0, fails = 0, viol = 0;
  logic [7:0] rd_buf [16];
  logic ack, prev_oe;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eep_i2c_slave #(.BUSY_CYCLES(BUSY)) i_eep_i2c_slave (
    .clk_i(clk), .rst_ni, .scl_i(scl_m), .sda_i(sda_bus),
    .dev_addr_i(3'b101), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  // R2 monitor: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rst_ni && sda_oe !== prev_oe && scl_m) viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); repeat (Q) @(posedge clk); #1; endtask
  task automatic bus_start(); sda_m = 1; tick(); scl_m = 1; tick(); sda_m = 0; tick(); scl_m = 0; tick(); endtask
  task automatic bus_stop(); sda_m = 0; tick(); scl_m = 1; tick(); sda_m = 1; tick(); endtask
  task automatic clk_bit(input logic b);
    sda_m = b; tick(); scl_m = 1; tick(); tick(); scl_m = 0; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda_m = 1; tick(); scl_m = 1; tick(); a = ~sda_bus; tick(); scl_m = 0; tick();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(); scl_m = 1; tick(); b[i] = sda_bus; tick(); scl_m = 0; tick();
    end
    clk_bit(~give_ack);
    sda_m = 1;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] base, output logic ok);
    logic k;
    bus_start(); send_byte(SEL_W, ok); send_byte(a, k); ok &= k;
    for (int i = 0; i < n; i++) begin send_byte(base + 8'(i), k); ok &= k; end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input int n, output logic ok);
    logic k;
    bus_start(); send_byte(SEL_W, ok); send_byte(a, k); ok &= k;
    bus_start(); send_byte(SEL_R, k); ok &= k;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rd_buf[i]);
    bus_stop();
  endtask

  task automatic wait_busy(); repeat (BUSY + 50) @(posedge clk); #1; endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    repeat (5) @(posedge clk); #1;
    check(sda_oe == 1'b0, "R11 reset released", int'(sda_oe), 0);
    rst_ni = 1'b1;
    repeat (5) @(posedge clk); #1;
    check(sda_oe == 1'b0, "R11 idle after reset", int'(sda_oe), 0);

    // table: byte write then random read
    for (int v = 0; v < 8; v++) begin
      do_write(VEC[v][15:8], 1, VEC[v][7:0], ack);
      check(ack, "R4 write acks", int'(ack), 1);
      wait_busy();
      do_read(VEC[v][15:8], 1, ack);
      check(ack, "R3 select ack", int'(ack), 1);
      check(rd_buf[0] == VEC[v][7:0], "R9 random read", rd_buf[0], VEC[v][7:0]);
    end

    // R3 foreign selects
    bus_start(); send_byte(8'hA8, ack); bus_stop();
    check(!ack, "R3 wrong device bits", int'(ack), 0);
    bus_start(); send_byte(8'hEA, ack); bus_stop();
    check(!ack, "R3 wrong code", int'(ack), 0);

    // R9 sequential wrap, R10 nack ends read
    do_read(8'hFE, 3, ack);
    check(rd_buf[0] == 8'hE1, "R9 seq byte0", rd_buf[0], 8'hE1);
    check(rd_buf[1] == 8'h1F, "R9 seq byte1", rd_buf[1], 8'h1F);
    check(rd_buf[2] == 8'h3C, "R9 wrap to 00", rd_buf[2], 8'h3C);
    check(sda_oe == 1'b0, "R10 released after nack", int'(sda_oe), 0);

    // R5 page wrap: 10 bytes from 0x16
    do_write(8'h16, 10, 8'h30, ack);
    check(ack, "R5 page write acks", int'(ack), 1);
    wait_busy();
    do_read(8'h10, 8, ack);
    for (int o = 0; o < 8; o++) begin
      exp = (o >= 6) ? 8'(8'h30 + o + 2) : 8'(8'h30 + o + 2);
      check(rd_buf[o] == exp, "R5 page wrap", rd_buf[o], exp);
    end

    // R6 repeated start discards buffered data
    do_write(8'h40, 1, 8'h5A, ack);
    wait_busy();
    bus_start(); send_byte(SEL_W, ack); send_byte(8'h40, ack); send_byte(8'h11, ack);
    bus_start(); bus_stop();
    do_read(8'h40, 1, ack);
    check(ack, "R6 no busy after discard", int'(ack), 1);
    check(rd_buf[0] == 8'h5A, "R6 discard", rd_buf[0], 8'h5A);

    // R7 write protect
    wp = 1'b1;
    do_write(8'h80, 1, 8'hEE, ack); wait_busy();
    do_write(8'h00, 1, 8'hEE, ack); wait_busy();
    do_read(8'h80, 1, ack);
    check(rd_buf[0] == 8'h7E, "R7 upper blocked", rd_buf[0], 8'h7E);
    do_read(8'h00, 1, ack);
    check(rd_buf[0] == 8'hEE, "R7 lower writable", rd_buf[0], 8'hEE);
    wp = 1'b0;
    do_write(8'h80, 1, 8'hEE, ack); wait_busy();
    do_read(8'h80, 1, ack);
    check(rd_buf[0] == 8'hEE, "R7 unprotected", rd_buf[0], 8'hEE);

    // R8 busy window
    do_write(8'h20, 1, 8'h77, ack);
    bus_start(); send_byte(SEL_W, ack); bus_stop();
    check(!ack, "R8 nack while busy", int'(ack), 0);
    wait_busy();
    do_read(8'h20, 1, ack);
    check(ack, "R8 ack after busy", int'(ack), 1);
    check(rd_buf[0] == 8'h77, "R8 data committed", rd_buf[0], 8'h77);

    // R1 stop mid-byte, then normal traffic
    bus_start(); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); bus_stop();
    check(sda_oe == 1'b0, "R1 idle after abort", int'(sda_oe), 0);
    do_read(8'h20, 1, ack);
    check(ack && rd_buf[0] == 8'h77, "R1 recovery", rd_buf[0], 8'h77);

    check(viol == 0, "R2 oe only with SCL low", viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule